// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the address phase of an I2C transfer selects the local device as a slave. A byte-level front end gives it strobes for START (and repeated START) and STOP, and a byte-valid strobe with each received byte. The matcher takes the address byte, or the two-byte 10-bit header sequence, that follows each START. It compares that address with the configured addresses and raises the flags that the rest of the slave controller needs to carry on with the transfer.

Two addresses can be configured: a primary address and an upper address. There is an option to accept every address that lies strictly between them, and such a hit raises its own range flag. General-call recognition and 10-bit addressing are both optional. In 10-bit addressing the upper address takes its three top bits from the primary address. When wakeup is enabled, a completed match also produces a one-cycle wakeup pulse. A sticky flag records every STOP on the bus until it is cleared.

All outputs are registered. Each reacts in the clock cycle after the strobe that causes it.

Top module: `i2c_addr_match`

## Requirements
- R1: When 10-bit mode is off, the first byte after a START matches the primary address if byte bits 7..1 equal `cfg_prim_i[6:0]` and that value is non-zero. In the following cycle `addressed_o` goes to 1 and `ack_req_o` is high for exactly one cycle.
- R2: A non-zero `cfg_upper_i` is a second address, matched exactly in the same way as the primary. A value of zero turns matching on the upper address off.
- R3: With `cfg_range_en_i` set, an address strictly greater than the primary and strictly less than the upper also matches and sets `range_hit_o`. This holds only when both addresses are non-zero and the upper is greater than the primary. An exact hit on the primary or the upper address leaves `range_hit_o` at 0.
- R4: With `cfg_gc_en_i` set, the byte 0x00 (address zero, write) matches and sets `gen_call_o`. The byte 0x01 does not match, and 0x00 does not match when general call is disabled. Address zero never matches through the primary or the upper address.
- R5: On a match, `slave_tx_o` equals the R/W bit of the address phase: 1 (read) means the slave transmits, 0 means it receives.
- R6: In 10-bit mode, `cfg_prim_i[9:0]` is the primary address. The header byte is 11110, then address bits 9..8, then R/W. If the header's address bits equal `cfg_prim_i[9:8]`, `ack_req_o` pulses and the next byte is taken as address bits 7..0. `addressed_o` is set only after that second byte matches. The 10-bit upper address is `{cfg_prim_i[9:7], cfg_upper_i}`.
- R7: An address byte that does not match produces no `ack_req_o`, leaves all flags at 0, and sends the matcher idle. It ignores further bytes until the next START.
- R8: A START or repeated START clears `addressed_o`, `range_hit_o`, `gen_call_o` and `slave_tx_o` in the next cycle, and the next byte is evaluated again as an address.
- R9: A STOP clears those four flags and sets `stop_seen_o`. `stop_seen_o` stays at 1 until `stop_clr_i` is pulsed. STOP takes priority over a clear in the same cycle, and over START and byte strobes.
- R10: With `cfg_wake_en_i` set, a completed match gives a one-cycle `wakeup_o` in the same cycle as `addressed_o` first rises. No pulse is given when wakeup is disabled, and none on a 10-bit header.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START seen (one-cycle strobe) |
| stop_i | input | 1 | STOP seen (one-cycle strobe) |
| byte_vld_i | input | 1 | `byte_i` holds a received byte |
| byte_i | input | 8 | Received byte |
| cfg_prim_i | input | 10 | Primary address, right-aligned; bits 6..0 in 7-bit mode |
| cfg_upper_i | input | 7 | Upper address, 0 turns it off |
| cfg_ten_bit_i | input | 1 | 10-bit addressing mode |
| cfg_gc_en_i | input | 1 | General-call recognition enable |
| cfg_range_en_i | input | 1 | Range matching enable |
| cfg_wake_en_i | input | 1 | Wakeup pulse enable |
| stop_clr_i | input | 1 | Clear the STOP-seen flag |
| addressed_o | output | 1 | Selected as slave |
| range_hit_o | output | 1 | Selected through range matching |
| gen_call_o | output | 1 | Selected through general call |
| slave_tx_o | output | 1 | Slave transmits (read transfer) |
| ack_req_o | output | 1 | Acknowledge the address byte just received |
| wakeup_o | output | 1 | Wakeup pulse on a match |
| stop_seen_o | output | 1 | Sticky STOP-detected flag |

## Verification
The assertions assume the front end sends strobes only in meaningful order. A byte strobe arrives after a START, and the configuration stays constant between a START and the end of its address phase. The stimulus meets this: it changes the configuration only while the bus is idle after a STOP or before a START, and it sends each strobe as a single-cycle pulse. A behavioural reference model runs alongside the design and checks every output on every clock. The directed sequences cover exact, upper, range, boundary, general-call, 10-bit and rejected addresses, as well as colliding STOP and clear strobes.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int BYTE_W = 8;
  localparam int A7_W   = 7;
  localparam int A10_W  = 10;
  localparam int HI_W   = A10_W - BYTE_W;

  localparam logic [4:0] HDR10_MARK = 5'b11110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_DONE
  } am_state_e;

  typedef struct packed {
    logic prim;
    logic upper;
    logic range_h;
  } am_hits_t;
endpackage

// File: rtl/am_cfg_decode.sv
module am_cfg_decode #(
  parameter int A7_W  = 7,
  parameter int A10_W = 10,
  localparam int EXT_W = A10_W - A7_W
) (
  input  logic [A10_W-1:0] prim_cfg_i,
  input  logic [A7_W-1:0]  upper_cfg_i,
  input  logic             range_en_i,
  output logic [A7_W-1:0]  prim7_o,
  output logic [A7_W-1:0]  upper7_o,
  output logic [A10_W-1:0] prim10_o,
  output logic [A10_W-1:0] upper10_o,
  output logic             upper_on_o,
  output logic             rng7_ok_o,
  output logic             rng10_ok_o
);
  assign prim7_o    = prim_cfg_i[A7_W-1:0];
  assign upper7_o   = upper_cfg_i;
  assign prim10_o   = prim_cfg_i;
  // upper address borrows the top bits of the primary in 10-bit mode
  assign upper10_o  = {prim_cfg_i[A10_W-1 -: EXT_W], upper_cfg_i};
  assign upper_on_o = |upper_cfg_i;

  assign rng7_ok_o  = range_en_i && (|prim7_o) && upper_on_o && (upper7_o > prim7_o);
  assign rng10_ok_o = range_en_i && (|prim10_o) && upper_on_o && (upper10_o > prim10_o);
endmodule

// File: rtl/am_cmp.sv
module am_cmp
  import i2c_am_pkg::*;
#(
  parameter int W = 7
) (
  input  logic [W-1:0] cand_i,
  input  logic [W-1:0] prim_i,
  input  logic [W-1:0] upper_i,
  input  logic         upper_on_i,
  input  logic         range_ok_i,
  output am_hits_t     hits_o
);
  always_comb begin
    hits_o.prim    = (|cand_i) && (cand_i == prim_i);
    hits_o.upper   = upper_on_i && (cand_i == upper_i);
    hits_o.range_h = range_ok_i && (cand_i > prim_i) && (cand_i < upper_i);
  end
endmodule

// File: rtl/am_ctrl.sv
module am_ctrl
  import i2c_am_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ten_bit_i,
  input  logic              gc_en_i,
  input  logic              wake_en_i,
  input  logic              stop_clr_i,
  input  logic [HI_W-1:0]   prim_hi_i,
  input  am_hits_t          hits7_i,
  input  am_hits_t          hits10_i,
  output logic [HI_W-1:0]   hdr_hi_o,
  output logic              addressed_o,
  output logic              range_hit_o,
  output logic              gen_call_o,
  output logic              slave_tx_o,
  output logic              ack_req_o,
  output logic              wakeup_o,
  output logic              stop_seen_o
);
  am_state_e state_q;
  logic      hdr_rw_q;
  logic      gc_hit, hdr_ok, first_hit, second_hit;

  assign gc_hit     = gc_en_i && (byte_i == '0);
  assign hdr_ok     = ten_bit_i && (byte_i[7:3] == HDR10_MARK) && (byte_i[2:1] == prim_hi_i);
  assign first_hit  = gc_hit || (!ten_bit_i && (hits7_i.prim || hits7_i.upper || hits7_i.range_h));
  assign second_hit = hits10_i.prim || hits10_i.upper || hits10_i.range_h;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      hdr_hi_o    <= '0;
      hdr_rw_q    <= 1'b0;
      addressed_o <= 1'b0;
      range_hit_o <= 1'b0;
      gen_call_o  <= 1'b0;
      slave_tx_o  <= 1'b0;
      ack_req_o   <= 1'b0;
      wakeup_o    <= 1'b0;
      stop_seen_o <= 1'b0;
    end else begin
      ack_req_o <= 1'b0;
      wakeup_o  <= 1'b0;
      if (stop_i) begin
        state_q     <= ST_IDLE;
        addressed_o <= 1'b0;
        range_hit_o <= 1'b0;
        gen_call_o  <= 1'b0;
        slave_tx_o  <= 1'b0;
        stop_seen_o <= 1'b1;
      end else begin
        if (stop_clr_i) stop_seen_o <= 1'b0;
        if (start_i) begin
          state_q     <= ST_FIRST;
          addressed_o <= 1'b0;
          range_hit_o <= 1'b0;
          gen_call_o  <= 1'b0;
          slave_tx_o  <= 1'b0;
        end else if (byte_vld_i) begin
          unique case (state_q)
            ST_FIRST: begin
              if (first_hit) begin
                addressed_o <= 1'b1;
                range_hit_o <= !gc_hit && hits7_i.range_h;
                gen_call_o  <= gc_hit;
                slave_tx_o  <= byte_i[0];
                ack_req_o   <= 1'b1;
                wakeup_o    <= wake_en_i;
                state_q     <= ST_DONE;
              end else if (hdr_ok) begin
                hdr_hi_o  <= byte_i[2:1];
                hdr_rw_q  <= byte_i[0];
                ack_req_o <= 1'b1;
                state_q   <= ST_SECOND;
              end else begin
                state_q <= ST_DONE;
              end
            end
            ST_SECOND: begin
              if (second_hit) begin
                addressed_o <= 1'b1;
                range_hit_o <= hits10_i.range_h;
                slave_tx_o  <= hdr_rw_q;
                ack_req_o   <= 1'b1;
                wakeup_o    <= wake_en_i;
              end
              state_q <= ST_DONE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R9
  stop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !addressed_o && stop_seen_o);
  // R9
  stop_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_seen_o && !stop_clr_i |=> stop_seen_o);
  // R8
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !stop_i |=> !addressed_o && !ack_req_o);
  // R3
  range_in_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_hit_o |-> addressed_o && !gen_call_o);
  // R4
  gc_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_call_o |-> addressed_o && !slave_tx_o);
  // R10
  wake_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wakeup_o |-> $past(wake_en_i) && addressed_o && ack_req_o);
  // R1
  ack_on_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o |-> $past(byte_vld_i));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic [9:0]  cfg_prim_i,
  input  logic [6:0]  cfg_upper_i,
  input  logic        cfg_ten_bit_i,
  input  logic        cfg_gc_en_i,
  input  logic        cfg_range_en_i,
  input  logic        cfg_wake_en_i,
  input  logic        stop_clr_i,
  output logic        addressed_o,
  output logic        range_hit_o,
  output logic        gen_call_o,
  output logic        slave_tx_o,
  output logic        ack_req_o,
  output logic        wakeup_o,
  output logic        stop_seen_o
);
  logic [A7_W-1:0]  prim7, upper7;
  logic [A10_W-1:0] prim10, upper10, cand10;
  logic             upper_on, rng7_ok, rng10_ok;
  logic [HI_W-1:0]  hdr_hi;
  am_hits_t         hits7, hits10;

  am_cfg_decode #(.A7_W(A7_W), .A10_W(A10_W)) u_cfg (
    .prim_cfg_i (cfg_prim_i),
    .upper_cfg_i(cfg_upper_i),
    .range_en_i (cfg_range_en_i),
    .prim7_o    (prim7),
    .upper7_o   (upper7),
    .prim10_o   (prim10),
    .upper10_o  (upper10),
    .upper_on_o (upper_on),
    .rng7_ok_o  (rng7_ok),
    .rng10_ok_o (rng10_ok)
  );

  am_cmp #(.W(A7_W)) u_cmp7 (
    .cand_i    (byte_i[7:1]),
    .prim_i    (prim7),
    .upper_i   (upper7),
    .upper_on_i(upper_on),
    .range_ok_i(rng7_ok),
    .hits_o    (hits7)
  );

  assign cand10 = {hdr_hi, byte_i};

  am_cmp #(.W(A10_W)) u_cmp10 (
    .cand_i    (cand10),
    .prim_i    (prim10),
    .upper_i   (upper10),
    .upper_on_i(upper_on),
    .range_ok_i(rng10_ok),
    .hits_o    (hits10)
  );

  am_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .byte_i     (byte_i),
    .ten_bit_i  (cfg_ten_bit_i),
    .gc_en_i    (cfg_gc_en_i),
    .wake_en_i  (cfg_wake_en_i),
    .stop_clr_i (stop_clr_i),
    .prim_hi_i  (prim10[A10_W-1 -: HI_W]),
    .hits7_i    (hits7),
    .hits10_i   (hits10),
    .hdr_hi_o   (hdr_hi),
    .addressed_o(addressed_o),
    .range_hit_o(range_hit_o),
    .gen_call_o (gen_call_o),
    .slave_tx_o (slave_tx_o),
    .ack_req_o  (ack_req_o),
    .wakeup_o   (wakeup_o),
    .stop_seen_o(stop_seen_o)
  );
endmodule

// File: tb/i2c_addr_match_tb.sv
`timescale 1ns/1ps
module i2c_addr_match_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, stop, bvld, sclr;
  logic [7:0] bdat;
  logic [9:0] prim;
  logic [6:0] upper;
  logic ten, gc_en, rng_en, wk_en;
  logic addressed, range_hit, gen_call, slave_tx, ack_req, wakeup, stop_seen;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_addr_match u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .byte_vld_i(bvld), .byte_i(bdat), .cfg_prim_i(prim), .cfg_upper_i(upper),
    .cfg_ten_bit_i(ten), .cfg_gc_en_i(gc_en), .cfg_range_en_i(rng_en),
    .cfg_wake_en_i(wk_en), .stop_clr_i(sclr),
    .addressed_o(addressed), .range_hit_o(range_hit), .gen_call_o(gen_call),
    .slave_tx_o(slave_tx), .ack_req_o(ack_req), .wakeup_o(wakeup),
    .stop_seen_o(stop_seen)
  );

  // behavioural reference model: 0 idle, 1 first byte, 2 second byte, 3 done
  int m_st, m_hi, m_rw;
  bit m_addr, m_rng, m_gc, m_tx, m_ack, m_wake, m_stop;

  task automatic m_match(input bit r, input bit g, input bit t);
    m_addr = 1; m_rng = r; m_gc = g; m_tx = t; m_ack = 1; m_wake = wk_en;
  endtask

  always @(posedge clk or negedge rst_n) begin
    int a, p7, u7, p10, u10;
    bit r7, r10, hp, hu, hr;
    if (!rst_n) begin
      m_st = 0; m_hi = 0; m_rw = 0;
      {m_addr, m_rng, m_gc, m_tx, m_ack, m_wake, m_stop} = '0;
    end else begin
      m_ack = 0; m_wake = 0;
      p7 = int'(prim) % 128; u7 = int'(upper); p10 = int'(prim);
      u10 = (p10 / 128) * 128 + u7;
      r7  = rng_en && p7 != 0 && u7 != 0 && u7 > p7;
      r10 = rng_en && p10 != 0 && u7 != 0 && u10 > p10;
      if (stop) begin
        m_st = 0; m_addr = 0; m_rng = 0; m_gc = 0; m_tx = 0; m_stop = 1;
      end else begin
        if (sclr) m_stop = 0;
        if (start) begin
          m_st = 1; m_addr = 0; m_rng = 0; m_gc = 0; m_tx = 0;
        end else if (bvld && m_st == 1) begin
          m_st = 3;
          if (gc_en && bdat == 0) m_match(0, 1, 0);
          else if (!ten) begin
            a = int'(bdat) / 2;
            hp = a != 0 && a == p7; hu = u7 != 0 && a == u7;
            hr = r7 && a > p7 && a < u7;
            if (hp || hu || hr) m_match(hr, 0, bdat[0]);
          end else if (int'(bdat) / 8 == 30 && (int'(bdat) / 2) % 4 == p10 / 256) begin
            m_hi = (int'(bdat) / 2) % 4; m_rw = bdat[0]; m_ack = 1; m_st = 2;
          end
        end else if (bvld && m_st == 2) begin
          m_st = 3;
          a = m_hi * 256 + int'(bdat);
          hp = a != 0 && a == p10; hu = u7 != 0 && a == u10;
          hr = r10 && a > p10 && a < u10;
          if (hp || hu || hr) m_match(hr, 0, m_rw[0]);
        end
      end
    end
  end

  task automatic cmp1(input string req, input string nm, input bit act, input bit exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      cmp1("R1", "addressed", addressed, m_addr);
      cmp1("R3", "range_hit", range_hit, m_rng);
      cmp1("R4", "gen_call", gen_call, m_gc);
      cmp1("R5", "slave_tx", slave_tx, m_tx);
      cmp1("R1", "ack_req", ack_req, m_ack);
      cmp1("R10", "wakeup", wakeup, m_wake);
      cmp1("R9", "stop_seen", stop_seen, m_stop);
    end
  end

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s outputs actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] outs();
    return {addressed, range_hit, gen_call, slave_tx, ack_req, wakeup, stop_seen};
  endfunction

  task automatic tick();
    @(negedge clk);
    {start, stop, bvld, sclr} = '0;
  endtask
  task automatic do_start(); @(negedge clk); start = 1; tick(); endtask
  task automatic do_stop();  @(negedge clk); stop = 1;  tick(); endtask
  task automatic do_clr();   @(negedge clk); sclr = 1;  tick(); endtask
  task automatic do_byte(input logic [7:0] b);
    @(negedge clk); bvld = 1; bdat = b; tick();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // output order: addressed range gc tx ack wake stop_seen
  initial begin
    {start, stop, bvld, sclr} = '0;
    bdat = '0; prim = 10'h028; upper = 7'h30;
    {ten, gc_en, rng_en, wk_en} = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset", outs(), 7'b0000000);
    rst_n = 1;
    @(negedge clk);
    chk("R11 after release", outs(), 7'b0000000);

    do_start(); do_byte(8'h51);
    chk("R1 primary read / R5", outs(), 7'b1001100);
    @(negedge clk);
    chk("R1 ack one cycle", outs(), 7'b1001000);
    do_stop();
    chk("R9 stop clears and sets flag", outs(), 7'b0000001);
    @(negedge clk);
    chk("R9 sticky", outs(), 7'b0000001);
    do_clr();
    chk("R9 clear", outs(), 7'b0000000);

    wk_en = 1;
    do_start(); do_byte(8'h60);
    chk("R2 upper write / R10 wake", outs(), 7'b1000110);
    do_start();
    chk("R8 repeated start clears", outs(), 7'b0000000);
    do_byte(8'h58);
    chk("R3 range off no match / R7", outs(), 7'b0000000);
    do_byte(8'h50);
    chk("R7 later byte ignored", outs(), 7'b0000000);

    rng_en = 1;
    do_start(); do_byte(8'h59);
    chk("R3 range hit read", outs(), 7'b1101110);
    do_start(); do_byte(8'h50);
    chk("R3 exact primary no range flag", outs(), 7'b1000110);
    do_start(); do_byte(8'h52);
    chk("R3 just above primary", outs(), 7'b1100110);
    do_start(); do_byte(8'h62);
    chk("R3 above upper no match", outs(), 7'b0000000);
    do_stop(); do_clr();

    upper = 7'h00;
    do_start(); do_byte(8'h58);
    chk("R2 upper zero disables range", outs(), 7'b0000000);
    do_start(); do_byte(8'h00);
    chk("R4 gc disabled", outs(), 7'b0000000);
    gc_en = 1;
    do_start(); do_byte(8'h00);
    chk("R4 general call", outs(), 7'b1010110);
    do_start(); do_byte(8'h01);
    chk("R4 read on address zero", outs(), 7'b0000000);
    prim = 10'h000; gc_en = 0;
    do_start(); do_byte(8'h00);
    chk("R4 zero primary never matches", outs(), 7'b0000000);
    do_stop(); do_clr();

    wk_en = 0; ten = 1; prim = 10'h2A5; upper = 7'h30; rng_en = 0;
    do_start(); do_byte(8'hF4);
    chk("R6 header ack only", outs(), 7'b0000100);
    do_byte(8'hA5);
    chk("R6 10-bit primary write", outs(), 7'b1000100);
    do_start(); do_byte(8'hF5); do_byte(8'hB0);
    chk("R6 10-bit upper read / R5", outs(), 7'b1001100);
    do_start(); do_byte(8'hF4); do_byte(8'hA6);
    chk("R6 10-bit mismatch", outs(), 7'b0000000);
    rng_en = 1; wk_en = 1;
    do_start(); do_byte(8'hF4); do_byte(8'hA6);
    chk("R3 10-bit range", outs(), 7'b1100110);
    do_start(); do_byte(8'hF2);
    chk("R7 wrong header", outs(), 7'b0000000);
    do_byte(8'hA5);
    chk("R7 ignored after bad header", outs(), 7'b0000000);
    do_start(); do_byte(8'h51);
    chk("R6 7-bit form ignored in 10-bit mode", outs(), 7'b0000000);

    @(negedge clk); stop = 1; sclr = 1; tick();
    chk("R9 stop wins over clear", outs(), 7'b0000001);
    @(negedge clk); stop = 1; start = 1; tick();
    do_byte(8'hF4);
    chk("R9 stop wins over start", outs(), 7'b0000001);
    do_clr();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule